// File: doc/BRIEF.md
# Virtual Interrupt Completion Handler

This block models the completion side of a virtual CPU interface in an interrupt controller. A guest signals the end of an interrupt (EOI) or deactivates one (DIR). The block then updates a small set of list-register entries, a vector of active-priority bits and a hypervisor control word that holds a 5-bit counter of completions that found no matching entry. The list registers, the active-priority vector and the control word are all visible on output ports. A load port lets the hypervisor side place entries and values.

EOI and DIR requests arrive on valid/ready channels. The EOI channel always accepts, so its ready is tied high. The DIR channel has a one-entry holding slot. A DIR that arrives in the same cycle as an EOI is accepted and parked, and it runs in the next cycle in which no EOI runs. While a DIR is parked, `dir_ready` is low, and a DIR offered during that time is neither accepted nor acted on. The sender must hold it until ready returns. `eoi_mode` is a plain level input. It selects whether an EOI also deactivates the entry (0) or leaves deactivation to DIR (1).

Top module: `vcc_completion`

## Requirements
- R1: After a synchronous active-high reset, every list-register state (00 invalid, 01 pending, 10 active, 11 pending-and-active), the active-priority vector and the control word read zero, and `dir_ready` is 1.
- R2: An EOI or DIR whose ID is 1020, 1021, 1022 or 1023 changes nothing, including the counter.
- R3: An EOI with an ID below 1020 clears the lowest-numbered set bit of the active-priority vector on the next clock edge. If the vector is zero, the EOI changes nothing and the counter does not move.
- R4: When an EOI has cleared a priority bit and no entry holds its ID in state 10 or 11, the counter in control-word bits [31:27] increases by one, modulo 32, and bits [26:0] keep their value.
- R5: With `eoi_mode` 0, an EOI that cleared a priority bit and matches an entry clears bit 1 of that entry's state (10 becomes 00, 11 becomes 01). With `eoi_mode` 1, the entry is left unchanged.
- R6: With `eoi_mode` 1, a DIR clears bit 1 of the matching entry's state. A DIR that matches no entry increments the counter instead. A DIR never changes the active-priority vector.
- R7: With `eoi_mode` 0, a DIR changes no entry and does not increment the counter.
- R8: An ID matches only an entry that holds that ID in state 10 or 11. An entry in state 01 never matches, and when several entries match, the lowest index is the one acted on.
- R9: When EOI and DIR are valid in the same cycle, the EOI takes effect on that edge. The DIR takes effect one edge later, and `dir_ready` reads 0 for the cycle in between.
- R10: A hypervisor load of an entry, of the priority vector or of the control word replaces that item on the next edge. In the same cycle the load wins over any completion update to that item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_mode | input | 1 | 0: EOI also deactivates; 1: EOI only drops priority |
| eoi_valid | input | 1 | EOI request valid |
| eoi_ready | output | 1 | EOI channel ready, always 1 |
| eoi_id | input | 10 | Interrupt ID of the EOI |
| dir_valid | input | 1 | DIR request valid |
| dir_ready | output | 1 | DIR channel ready, low while a DIR is parked |
| dir_id | input | 10 | Interrupt ID of the DIR |
| lr_wr_en | input | 1 | Load one list-register entry |
| lr_wr_idx | input | 2 | Entry index to load |
| lr_wr_id | input | 10 | Virtual ID to load |
| lr_wr_state | input | 2 | State to load |
| lr_wr_prio | input | 5 | Priority to load |
| apr_wr_en | input | 1 | Load the active-priority vector |
| apr_wr_data | input | 32 | Active-priority value to load |
| hcr_wr_en | input | 1 | Load the control word |
| hcr_wr_data | input | 32 | Control word value to load |
| lr_state_o | output | 8 | Entry states, entry i at bits [2i+1:2i] |
| lr_id_o | output | 40 | Entry IDs, entry i at bits [10i+9:10i] |
| lr_prio_o | output | 20 | Entry priorities, entry i at bits [5i+4:5i] |
| apr_o | output | 32 | Active-priority vector |
| hcr_o | output | 32 | Control word, counter in [31:27] |

## Verification
A wrong ID match or a wrong priority choice shows up at the ports on the edge right after the request. It appears as a wrong entry state, as a priority bit that did or did not clear, or as a counter step that did or did not happen. A fault in the DIR holding slot shows as `dir_ready` staying high in the cycle after a collision, or as the parked DIR's effect arriving one edge too early or too late. Every one of these is visible within two cycles of the request. Each request is therefore compared against the expected state at the very next falling edge.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int ID_W = 10;
  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    LR_INVALID  = 2'b00,
    LR_PENDING  = 2'b01,
    LR_ACTIVE   = 2'b10,
    LR_PEND_ACT = 2'b11
  } lr_state_e;

  // Active bit is the upper state bit; clearing it is the deactivate step.
  function automatic logic [ST_W-1:0] drop_active(input logic [ST_W-1:0] st);
    return st & 2'b01;
  endfunction
endpackage

// File: rtl/vcc_lr_match.sv
module vcc_lr_match #(
  parameter int NUM_LR = 4,
  parameter int ID_W   = 10,
  parameter int ST_W   = 2,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic [NUM_LR*ID_W-1:0] ids,
  input  logic [NUM_LR*ST_W-1:0] states,
  input  logic [ID_W-1:0]        query,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [NUM_LR-1:0] eq;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_cmp
    // entry counts only while its active bit is set
    assign eq[i] = states[i*ST_W + 1] && (ids[i*ID_W +: ID_W] == query);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = NUM_LR - 1; k >= 0; k--) begin
      if (eq[k]) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vcc_apr_drop.sv
module vcc_apr_drop #(
  parameter int APR_W = 32
) (
  input  logic [APR_W-1:0] apr,
  output logic             any,
  output logic [APR_W-1:0] apr_next
);
  assign any      = |apr;
  assign apr_next = apr & (apr - APR_W'(1));

  always_comb begin
    if (!$isunknown(apr) && any) begin
      // R3
      drop_one_bit_chk: assert ($countones(apr_next) == $countones(apr) - 1);
    end
  end
endmodule

// File: rtl/vcc_dir_slot.sv
module vcc_dir_slot #(
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [ID_W-1:0] in_id,
  output logic            in_ready,
  input  logic            stall,
  output logic            out_valid,
  output logic [ID_W-1:0] out_id
);
  logic            held_q;
  logic [ID_W-1:0] held_id_q;

  assign in_ready  = !held_q;
  assign out_valid = held_q ? !stall : (in_valid && !stall);
  assign out_id    = held_q ? held_id_q : in_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q    <= 1'b0;
      held_id_q <= '0;
    end else if (held_q) begin
      if (!stall) held_q <= 1'b0;
    end else if (in_valid && stall) begin
      held_q    <= 1'b1;
      held_id_q <= in_id;
    end
  end

  // R9
  park_on_collision_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && stall) |=> (held_q && !in_ready));

  // R9
  release_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    (held_q && !stall) |=> in_ready);
endmodule

// File: rtl/vcc_completion.sv
module vcc_completion #(
  parameter int NUM_LR   = 4,
  parameter int PRIO_W   = 5,
  parameter int APR_W    = 32,
  parameter int HCR_W    = 32,
  parameter int CNT_LSB  = 27,
  parameter int CNT_W    = 5,
  parameter int RSV_BASE = 1020,
  localparam int ID_W    = vcc_pkg::ID_W,
  localparam int ST_W    = vcc_pkg::ST_W,
  localparam int IDX_W   = $clog2(NUM_LR)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     eoi_mode,
  input  logic                     eoi_valid,
  output logic                     eoi_ready,
  input  logic [ID_W-1:0]          eoi_id,
  input  logic                     dir_valid,
  output logic                     dir_ready,
  input  logic [ID_W-1:0]          dir_id,
  input  logic                     lr_wr_en,
  input  logic [IDX_W-1:0]         lr_wr_idx,
  input  logic [ID_W-1:0]          lr_wr_id,
  input  logic [ST_W-1:0]          lr_wr_state,
  input  logic [PRIO_W-1:0]        lr_wr_prio,
  input  logic                     apr_wr_en,
  input  logic [APR_W-1:0]         apr_wr_data,
  input  logic                     hcr_wr_en,
  input  logic [HCR_W-1:0]         hcr_wr_data,
  output logic [NUM_LR*ST_W-1:0]   lr_state_o,
  output logic [NUM_LR*ID_W-1:0]   lr_id_o,
  output logic [NUM_LR*PRIO_W-1:0] lr_prio_o,
  output logic [APR_W-1:0]         apr_o,
  output logic [HCR_W-1:0]         hcr_o
);
  import vcc_pkg::*;

  localparam logic [ID_W-1:0] RSV_ID = ID_W'(RSV_BASE);

  logic [ST_W-1:0]   st_q   [NUM_LR];
  logic [ID_W-1:0]   id_q   [NUM_LR];
  logic [PRIO_W-1:0] prio_q [NUM_LR];
  logic [APR_W-1:0]  apr_q;
  logic [HCR_W-1:0]  hcr_q;

  // EOI is always accepted; a DIR never runs in an EOI cycle
  assign eoi_ready = 1'b1;

  logic            dir_go;
  logic [ID_W-1:0] dir_run_id;

  vcc_dir_slot #(.ID_W(ID_W)) u_dir_slot (
    .clk      (clk),
    .rst      (rst),
    .in_valid (dir_valid),
    .in_id    (dir_id),
    .in_ready (dir_ready),
    .stall    (eoi_valid),
    .out_valid(dir_go),
    .out_id   (dir_run_id)
  );

  // One matcher shared by both paths, since they never run together
  logic [ID_W-1:0]  query;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  assign query = eoi_valid ? eoi_id : dir_run_id;

  vcc_lr_match #(.NUM_LR(NUM_LR), .ID_W(ID_W), .ST_W(ST_W)) u_match (
    .ids   (lr_id_o),
    .states(lr_state_o),
    .query (query),
    .hit   (hit),
    .idx   (hit_idx)
  );

  logic             apr_any;
  logic [APR_W-1:0] apr_dropped;

  vcc_apr_drop #(.APR_W(APR_W)) u_apr_drop (
    .apr     (apr_q),
    .any     (apr_any),
    .apr_next(apr_dropped)
  );

  logic eoi_drop, eoi_count, eoi_deact;
  logic dir_act, dir_count, dir_deact;
  logic deact, count_up;

  assign eoi_drop  = eoi_valid && (eoi_id < RSV_ID) && apr_any;
  assign eoi_count = eoi_drop && !hit;
  assign eoi_deact = eoi_drop && hit && !eoi_mode;

  assign dir_act   = dir_go && (dir_run_id < RSV_ID) && eoi_mode;
  assign dir_count = dir_act && !hit;
  assign dir_deact = dir_act && hit;

  assign deact    = eoi_deact || dir_deact;
  assign count_up = eoi_count || dir_count;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[i]   <= LR_INVALID;
        id_q[i]   <= '0;
        prio_q[i] <= '0;
      end else if (lr_wr_en && lr_wr_idx == IDX_W'(i)) begin
        st_q[i]   <= lr_wr_state;
        id_q[i]   <= lr_wr_id;
        prio_q[i] <= lr_wr_prio;
      end else if (deact && hit_idx == IDX_W'(i)) begin
        st_q[i] <= drop_active(st_q[i]);
      end
    end

    assign lr_state_o[i*ST_W +: ST_W]   = st_q[i];
    assign lr_id_o[i*ID_W +: ID_W]      = id_q[i];
    assign lr_prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)            apr_q <= '0;
    else if (apr_wr_en) apr_q <= apr_wr_data;
    else if (eoi_drop)  apr_q <= apr_dropped;
  end

  always_ff @(posedge clk) begin
    if (rst)            hcr_q <= '0;
    else if (hcr_wr_en) hcr_q <= hcr_wr_data;
    else if (count_up)  hcr_q[CNT_LSB +: CNT_W] <= hcr_q[CNT_LSB +: CNT_W] + CNT_W'(1);
  end

  assign apr_o = apr_q;
  assign hcr_o = hcr_q;

  // R2
  rsv_eoi_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_id >= RSV_ID && !apr_wr_en && !hcr_wr_en && !lr_wr_en)
      |=> ($stable(apr_q) && $stable(hcr_q) && $stable(lr_state_o)));

  // R3
  apr_zero_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && apr_q == '0 && !hcr_wr_en && !lr_wr_en)
      |=> ($stable(hcr_q) && $stable(lr_state_o)));

  // R4
  cnt_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !hcr_wr_en |=> (CNT_W'(hcr_q[CNT_LSB +: CNT_W] - $past(hcr_q[CNT_LSB +: CNT_W])) <= CNT_W'(1)
                    && hcr_q[CNT_LSB-1:0] == $past(hcr_q[CNT_LSB-1:0])));

  // R6
  dir_keeps_apr_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_go && !apr_wr_en) |=> $stable(apr_q));

  // R7
  dir_mode0_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_go && !eoi_mode && !lr_wr_en && !hcr_wr_en)
      |=> ($stable(lr_state_o) && $stable(hcr_q)));

  // R8
  pending_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (hit |-> lr_state_o[hit_idx*ST_W + 1]));
endmodule

// File: tb/test_vcc_completion.sv
`timescale 1ns/100ps
module test_vcc_completion;
  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic        eoi_mode, eoi_valid, eoi_ready, dir_valid, dir_ready;
  logic [9:0]  eoi_id, dir_id;
  logic        lr_wr_en, apr_wr_en, hcr_wr_en;
  logic [1:0]  lr_wr_idx, lr_wr_state;
  logic [9:0]  lr_wr_id;
  logic [4:0]  lr_wr_prio;
  logic [31:0] apr_wr_data, hcr_wr_data;
  logic [7:0]  lr_state_o;
  logic [39:0] lr_id_o;
  logic [19:0] lr_prio_o;
  logic [31:0] apr_o, hcr_o;

  vcc_completion i_vcc_completion (
    .clk(clk), .rst(rst), .eoi_mode(eoi_mode),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_id(eoi_id),
    .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_id(dir_id),
    .lr_wr_en(lr_wr_en), .lr_wr_idx(lr_wr_idx), .lr_wr_id(lr_wr_id),
    .lr_wr_state(lr_wr_state), .lr_wr_prio(lr_wr_prio),
    .apr_wr_en(apr_wr_en), .apr_wr_data(apr_wr_data),
    .hcr_wr_en(hcr_wr_en), .hcr_wr_data(hcr_wr_data),
    .lr_state_o(lr_state_o), .lr_id_o(lr_id_o), .lr_prio_o(lr_prio_o),
    .apr_o(apr_o), .hcr_o(hcr_o)
  );

  typedef struct packed {
    logic [7:0]  st;
    logic [31:0] apr;
    logic [31:0] hcr;
    logic        rdy;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int          m_id [4];
  logic [1:0]  m_st [4];
  logic [31:0] m_apr, m_hcr;
  bit          m_mode, m_held;
  int          m_held_id;

  function automatic int find_match(int id);
    for (int k = 0; k < 4; k++)
      if (m_id[k] == id && m_st[k][1]) return k;
    return -1;
  endfunction

  task automatic bump();
    m_hcr[31:27] = m_hcr[31:27] + 5'd1;
  endtask

  task automatic model_eoi(int id);
    int k;
    if (id >= 1020 || m_apr == 0) return;
    for (int b = 0; b < 32; b++)
      if (m_apr[b]) begin m_apr[b] = 1'b0; break; end
    k = find_match(id);
    if (k < 0) bump();
    else if (!m_mode) m_st[k][1] = 1'b0;
  endtask

  task automatic model_dir(int id);
    int k;
    if (id >= 1020 || !m_mode) return;
    k = find_match(id);
    if (k < 0) bump();
    else m_st[k][1] = 1'b0;
  endtask

  function automatic snap_t model_snap();
    snap_t s;
    for (int k = 0; k < 4; k++) s.st[k*2 +: 2] = m_st[k];
    s.apr = m_apr;
    s.hcr = m_hcr;
    s.rdy = !m_held;
    return s;
  endfunction

  // driver: one cycle of stimulus, model update, expected item pushed
  task automatic step(bit ev, int eid, bit dv, int did,
                      bit lw, int lidx, int lid, int lst, int lpr,
                      bit aw, logic [31:0] ad, bit hw, logic [31:0] hd,
                      string tag);
    @(negedge clk);
    eoi_valid = ev;  eoi_id = 10'(eid);
    dir_valid = dv;  dir_id = 10'(did);
    lr_wr_en = lw;   lr_wr_idx = 2'(lidx); lr_wr_id = 10'(lid);
    lr_wr_state = 2'(lst); lr_wr_prio = 5'(lpr);
    apr_wr_en = aw;  apr_wr_data = ad;
    hcr_wr_en = hw;  hcr_wr_data = hd;
    eoi_mode = m_mode;
    if (ev) model_eoi(eid);
    if (m_held) begin
      if (!ev) begin model_dir(m_held_id); m_held = 0; end
    end else if (dv) begin
      if (ev) begin m_held = 1; m_held_id = did; end
      else model_dir(did);
    end
    if (lw) begin m_id[lidx] = lid; m_st[lidx] = 2'(lst); end
    if (aw) m_apr = ad;
    if (hw) m_hcr = hd;
    @(posedge clk);
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic eoi(int id, string tag);
    step(1, id, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic dir(int id, string tag);
    step(0, 0, 1, id, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic load_lr(int idx, int id, int st, int pr, string tag);
    step(0, 0, 0, 0, 1, idx, id, st, pr, 0, 0, 0, 0, tag);
  endtask
  task automatic load_apr(logic [31:0] v, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, tag);
  endtask
  task automatic load_hcr(logic [31:0] v, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v, tag);
  endtask

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      snap_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{st: lr_state_o, apr: apr_o, hcr: hcr_o, rdy: dir_ready};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got st=%h apr=%h hcr=%h rdy=%b, expected st=%h apr=%h hcr=%h rdy=%b",
                 t, a.st, a.apr, a.hcr, a.rdy, e.st, e.apr, e.hcr, e.rdy);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; m_mode = 0;
    eoi_mode = 0; eoi_valid = 0; eoi_id = 0; dir_valid = 0; dir_id = 0;
    lr_wr_en = 0; lr_wr_idx = 0; lr_wr_id = 0; lr_wr_state = 0; lr_wr_prio = 0;
    apr_wr_en = 0; apr_wr_data = 0; hcr_wr_en = 0; hcr_wr_data = 0;
    for (int k = 0; k < 4; k++) begin m_id[k] = 0; m_st[k] = 0; end
    m_apr = 0; m_hcr = 0; m_held = 0; m_held_id = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tests++;
    if (lr_state_o !== 8'h0 || apr_o !== 32'h0 || hcr_o !== 32'h0 || dir_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: got st=%h apr=%h hcr=%h rdy=%b, expected 0 0 0 1",
               lr_state_o, apr_o, hcr_o, dir_ready);
    end

    // R10 loads
    load_lr(0, 40, 2, 3, "R10 load lr0");
    load_lr(1, 41, 3, 4, "R10 load lr1");
    load_lr(2, 42, 1, 5, "R10 load lr2");
    load_apr(32'h0000_000A, "R10 load apr");
    load_hcr(32'h0000_00A5, "R10 load hcr");

    m_mode = 0;
    eoi(40, "R3 R5 eoi mode0 deactivates active");
    eoi(1021, "R2 eoi reserved id ignored");
    eoi(41, "R5 eoi mode0 pend-active to pending");
    eoi(41, "R3 eoi with empty apr ignored");
    load_apr(32'h0000_0006, "R10 reload apr");
    eoi(42, "R4 R8 pending entry does not match, count");
    load_lr(0, 40, 2, 3, "R10 reload lr0");
    dir(40, "R7 dir in mode0 ignored");

    m_mode = 1;
    eoi(40, "R5 eoi mode1 keeps entry");
    dir(40, "R6 dir mode1 deactivates");
    dir(77, "R6 dir no match counts");
    dir(1023, "R2 dir reserved id ignored");
    load_hcr(32'hF800_0123, "R10 hcr counter at 31");
    load_apr(32'h8000_0000, "R10 apr top bit");
    eoi(500, "R4 counter wraps and low bits kept");

    load_lr(2, 42, 3, 1, "R10 lr2 pend-active");
    load_apr(32'h0000_0001, "R10 apr one bit");
    step(1, 42, 1, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 eoi first, dir parked");
    idle("R9 parked dir runs next cycle");

    load_lr(0, 60, 2, 0, "R10 lr0 id60");
    load_lr(1, 60, 2, 0, "R10 lr1 id60");
    dir(60, "R8 lowest index wins");
    step(0, 0, 1, 60, 1, 1, 61, 2, 2, 0, 0, 0, 0, "R10 load wins over dir clear");
    idle("R6 final settle");

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule